// File: doc/BRIEF.md
# GPU Command Packet Framer

This block sits between a command FIFO and a polygon renderer. It takes 32-bit command words over a valid/ready input and works out where each command packet starts and ends. The opcode sits in the top byte of a packet's first word. From that opcode the block picks a fixed parameter count, or, for the two polyline families, a terminator search. Drawing, fill and VRAM-copy packets go straight through to the renderer, one word per handshake. Each forwarded word carries its packet's opcode, a class code and a flag that marks the final word.

Some packets are absorbed rather than forwarded. Environment-setting words are stored in eight local registers, which are always visible on a flat output bus. Image write and image read headers are three words long. When the third word is accepted, the block hands the position and size words to a separate transfer engine as a one-cycle pulse. Opcodes that are not listed are single-word no-ops, so the stream never stalls on them. A packet that is only partly received simply waits for more input words. Nothing is discarded.

Top module: `fpkt_framer`

## Requirements
- R1: The opcode of a packet is bits 31:24 of its first word. Every forwarded word appears on `outWord` unchanged, and `outOpcode` carries that packet's opcode on every word of the packet.
- R2: Only three classes are forwarded: drawing (opcodes 0x20–0x7F) with class code 1, fill (0x02) with code 2, and VRAM copy (0x80–0x9F) with code 3. Words of any other opcode are accepted whatever the state of `outReady`, and they never raise `outValid`.
- R3: During a forwarded packet, `inReady` follows `outReady`. A word held back by a low `outReady` is presented again and is neither lost nor counted twice.
- R4: Fixed packets assert `outLast` on the word after their parameter count, and the next accepted word starts a new packet. The parameter counts are as follows. Fill has 2 and copy has 3. For polygons (0x20–0x3F), bit 3 selects a quad (4 vertices) over a triangle (3), and bit 2 (textured) doubles the vertex words. Bit 4 (shaded) adds one word per vertex after the first, which gives 3, 6, 4, 8, 5, 8, 7 and 11 for base opcodes 0x20 to 0x3C. Single lines 0x40–0x47 have 2 and 0x50–0x57 have 3. Rectangles have 2 (0x60), 3 (0x64), 1 (0x68, 0x70, 0x78) and 2 (0x6C, 0x74, 0x7C).
- R5: A monochrome polyline (0x48–0x4F) ends at the first word, at word index 3 or later, whose bits under mask 0xF000F000 equal 0x50005000. Matching words at indices 1 and 2 do not end it.
- R6: A shaded polyline (0x58–0x5F) tests for the same terminator only on even word indices from 4 onward. A match at an odd index does not end the packet.
- R7: An image header (0xA0–0xDF) is absorbed. In the cycle after its third word is accepted, `xferStart` is high for exactly one cycle. At that point `xferPos` holds word 1, `xferSize` holds word 2, and `xferRead` is 1 exactly when opcode bits 7:5 are 3'b110.
- R8: Gaps in `inValid` inside a packet leave its progress unchanged, and the packet completes when its remaining words arrive.
- R9: A word with opcode 0xE0–0xE7 is a single-word packet. It is stored whole into environment register (opcode & 7), which is shown on `envRegs` bits 32·i+31:32·i from the next cycle. It is not forwarded.
- R10: Any other opcode (for example 0x00, 0x01, 0xE8, 0xFF) is a single-word packet that is absorbed and changes no output.
- R11: A synchronous reset returns the framer to the start of a packet and loads each environment register i with (0xE0+i)<<24. It also keeps `xferStart` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Command word available |
| inWord | input | 32 | Command word |
| inReady | output | 1 | Command word accepted this cycle when inValid is high |
| outValid | output | 1 | Forwarded word valid toward renderer |
| outReady | input | 1 | Renderer can take a word |
| outWord | output | 32 | Forwarded word |
| outOpcode | output | 8 | Opcode of the packet being forwarded |
| outClass | output | 3 | Class code: 1 draw, 2 fill, 3 copy |
| outLast | output | 1 | Final word of the packet |
| xferStart | output | 1 | One-cycle image transfer start pulse |
| xferRead | output | 1 | Transfer direction, 1 for read |
| xferPos | output | 32 | Transfer position word |
| xferSize | output | 32 | Transfer size word |
| envRegs | output | 256 | Eight environment registers, register i in bits 32·i+31:32·i |

## Verification
The assertions assume the source holds `inWord` steady while a forwarded word is stalled, as any FIFO does. The bench keeps to this by presenting the same word again after each cycle with `outReady` low. They also assume reset is held for at least one clock before the first word arrives, and the bench holds it for two. Polylines are fed only with terminators inside the stream, so the saturating word counter never sees a packet long enough to matter. Back-to-back image headers are sent, which lets the one-cycle pulse rule be checked against headers that need at least three words each.

// File: rtl/fpkt_pkg.sv
package fpkt_pkg;

  localparam int OP_W = 8;

  typedef enum logic [2:0] {
    CLS_NOP   = 3'd0,
    CLS_DRAW  = 3'd1,
    CLS_FILL  = 3'd2,
    CLS_COPY  = 3'd3,
    CLS_IMGWR = 3'd4,
    CLS_IMGRD = 3'd5,
    CLS_ENV   = 3'd6
  } pkt_cls_e;

  typedef enum logic [1:0] {
    POLY_NONE   = 2'd0,
    POLY_FLAT   = 2'd1,
    POLY_SHADED = 2'd2
  } poly_mode_e;

  typedef struct packed {
    logic       envWe;
    logic [2:0] envSel;
    logic       posCap;
    logic       hdrFire;
    logic       hdrRead;
  } dp_strobe_t;

  function automatic pkt_cls_e classOf(input logic [OP_W-1:0] op);
    pkt_cls_e c;
    c = CLS_NOP;
    if (op == 8'h02)                             c = CLS_FILL;
    else if (op[7:5] inside {3'b001, 3'b010, 3'b011}) c = CLS_DRAW;
    else if (op[7:5] == 3'b100)                  c = CLS_COPY;
    else if (op[7:5] == 3'b101)                  c = CLS_IMGWR;
    else if (op[7:5] == 3'b110)                  c = CLS_IMGRD;
    else if (op[7:3] == 5'b11100)                c = CLS_ENV;
    return c;
  endfunction

  function automatic poly_mode_e polyOf(input logic [OP_W-1:0] op);
    poly_mode_e m;
    m = POLY_NONE;
    if (op[7:3] == 5'b01001)      m = POLY_FLAT;
    else if (op[7:3] == 5'b01011) m = POLY_SHADED;
    return m;
  endfunction

  // parameter words following the opcode word
  function automatic logic [3:0] paramCount(input logic [OP_W-1:0] op);
    logic [3:0] verts;
    logic [3:0] n;
    n = 4'd0;
    verts = op[3] ? 4'd4 : 4'd3;
    if (op == 8'h02) begin
      n = 4'd2;
    end else if (op[7:5] == 3'b001) begin
      n = op[2] ? (verts << 1) : verts;
      if (op[4]) n = n + verts - 4'd1;
    end else if (op[7:5] == 3'b010) begin
      n = op[4] ? (op[3] ? 4'd4 : 4'd3) : 4'd2;
    end else if (op[7:5] == 3'b011) begin
      n = (op[4:3] == 2'b00) ? (4'd2 + {3'd0, op[2]}) : (4'd1 + {3'd0, op[2]});
    end else if (op[7:5] == 3'b100) begin
      n = 4'd3;
    end else if (op[7:5] == 3'b101 || op[7:5] == 3'b110) begin
      n = 4'd2;
    end
    return n;
  endfunction

endpackage

// File: rtl/fpkt_ctrl.sv
module fpkt_ctrl
  import fpkt_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [OP_W-1:0]   outOpcode,
  output logic [2:0]        outClass,
  output logic              outLast,
  output dp_strobe_t        strobe
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [WORD_W-1:0] TERM_MASK = WORD_W'(32'hF000F000);
  localparam logic [WORD_W-1:0] TERM_VAL  = WORD_W'(32'h50005000);

  logic [CNT_W-1:0] cnt;
  logic             oddIdx;
  logic [OP_W-1:0]  curOp;

  logic             headWord;
  logic [OP_W-1:0]  opc;
  pkt_cls_e         cls;
  poly_mode_e       pmode;
  logic             forwardIt;
  logic             termHit;
  logic             isLast;
  logic             take;
  logic             isImg;

  always_comb begin
    headWord  = (cnt == '0);
    opc       = headWord ? inWord[WORD_W-1 -: OP_W] : curOp;
    cls       = classOf(opc);
    pmode     = polyOf(opc);
    forwardIt = (cls == CLS_DRAW) || (cls == CLS_FILL) || (cls == CLS_COPY);
    isImg     = (cls == CLS_IMGWR) || (cls == CLS_IMGRD);
    termHit   = ((inWord & TERM_MASK) == TERM_VAL);
    case (pmode)
      POLY_FLAT:   isLast = (cnt >= CNT_W'(3)) && termHit;
      POLY_SHADED: isLast = (cnt >= CNT_W'(4)) && !oddIdx && termHit;
      default:     isLast = (cnt == CNT_W'(paramCount(opc)));
    endcase
    inReady   = forwardIt ? outReady : 1'b1;
    outValid  = inValid && forwardIt;
    take      = inValid && inReady;
    outOpcode = opc;
    outClass  = cls;
    outLast   = isLast;
  end

  always_comb begin
    strobe.envWe   = take && headWord && (cls == CLS_ENV);
    strobe.envSel  = opc[2:0];
    strobe.posCap  = take && isImg && (cnt == CNT_W'(1));
    strobe.hdrFire = take && isImg && (cnt == CNT_W'(2));
    strobe.hdrRead = (cls == CLS_IMGRD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      oddIdx <= 1'b0;
      curOp  <= '0;
    end else if (take) begin
      if (headWord) curOp <= inWord[WORD_W-1 -: OP_W];
      if (isLast) begin
        cnt    <= '0;
        oddIdx <= 1'b0;
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
        oddIdx <= !oddIdx;
      end
    end
  end

  // a stalled forwarded word must not be consumed
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);

  // only draw, fill and copy reach the renderer
  assert_fwd_class_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outClass inside {3'd1, 3'd2, 3'd3}));

  // after a closing word the next word is a packet head
  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (take && outLast) |=> (cnt == '0));

  // an idle input leaves packet progress untouched
  assert_gap_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(cnt));

endmodule

// File: rtl/fpkt_dp.sv
module fpkt_dp
  import fpkt_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int NUM_ENV = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  dp_strobe_t                strobe,
  input  logic [WORD_W-1:0]         inWord,
  output logic [NUM_ENV*WORD_W-1:0] envRegs,
  output logic                      xferStart,
  output logic                      xferRead,
  output logic [WORD_W-1:0]         xferPos,
  output logic [WORD_W-1:0]         xferSize
);

  localparam int SEL_W = $clog2(NUM_ENV);

  logic [WORD_W-1:0] envQ [NUM_ENV];
  logic [WORD_W-1:0] posQ;

  for (genvar gi = 0; gi < NUM_ENV; gi++) begin : g_env
    localparam logic [7:0] RST_TAG = 8'(224 + gi);
    always_ff @(posedge clk) begin
      if (rst)
        envQ[gi] <= {RST_TAG, {(WORD_W-8){1'b0}}};
      else if (strobe.envWe && (SEL_W'(strobe.envSel) == SEL_W'(gi)))
        envQ[gi] <= inWord;
    end
    assign envRegs[gi*WORD_W +: WORD_W] = envQ[gi];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      posQ      <= '0;
      xferStart <= 1'b0;
      xferRead  <= 1'b0;
      xferPos   <= '0;
      xferSize  <= '0;
    end else begin
      if (strobe.posCap) posQ <= inWord;
      xferStart <= strobe.hdrFire;
      if (strobe.hdrFire) begin
        xferPos  <= posQ;
        xferSize <= inWord;
        xferRead <= strobe.hdrRead;
      end
    end
  end

  // a header spans three words, so two pulses cannot touch
  assert_xfer_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    xferStart |=> !xferStart);

  // environment state moves only after a write strobe
  assert_env_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(envRegs) |-> $past(strobe.envWe));

endmodule

// File: rtl/fpkt_framer.sv
module fpkt_framer
  import fpkt_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int NUM_ENV = 8,
  parameter int CNT_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  input  logic [WORD_W-1:0]         inWord,
  output logic                      inReady,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [WORD_W-1:0]         outWord,
  output logic [7:0]                outOpcode,
  output logic [2:0]                outClass,
  output logic                      outLast,
  output logic                      xferStart,
  output logic                      xferRead,
  output logic [WORD_W-1:0]         xferPos,
  output logic [WORD_W-1:0]         xferSize,
  output logic [NUM_ENV*WORD_W-1:0] envRegs
);

  dp_strobe_t strobe;

  assign outWord = inWord;

  fpkt_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .inValid(inValid), .inWord(inWord), .inReady(inReady),
    .outValid(outValid), .outReady(outReady),
    .outOpcode(outOpcode), .outClass(outClass), .outLast(outLast),
    .strobe(strobe)
  );

  fpkt_dp #(.WORD_W(WORD_W), .NUM_ENV(NUM_ENV)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .inWord(inWord),
    .envRegs(envRegs),
    .xferStart(xferStart), .xferRead(xferRead),
    .xferPos(xferPos), .xferSize(xferSize)
  );

endmodule

// File: tb/tb_fpkt_framer.sv
`timescale 1ns/1ps
module tb_fpkt_framer;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [31:0]  inWord = '0;
  logic         inReady, outValid, outLast, xferStart, xferRead;
  logic         outReady = 1'b1;
  logic [31:0]  outWord, xferPos, xferSize;
  logic [7:0]   outOpcode;
  logic [2:0]   outClass;
  logic [255:0] envRegs;

  always #2 clk = ~clk;

  fpkt_framer dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outWord(outWord),
    .outOpcode(outOpcode), .outClass(outClass), .outLast(outLast),
    .xferStart(xferStart), .xferRead(xferRead), .xferPos(xferPos),
    .xferSize(xferSize), .envRegs(envRegs)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int          idxM;
  logic [7:0]  opM;
  logic [31:0] posM;
  logic [31:0] envM [8];
  logic        expXs, expRead;
  logic [31:0] expPos, expSize;

  function automatic int mLen(input logic [7:0] op);
    if (op == 8'h02) return 2;
    if (op >= 8'h80 && op <= 8'h9F) return 3;
    if (op >= 8'hA0 && op <= 8'hDF) return 2;
    case (op & 8'hFC)
      8'h20: return 3;  8'h24: return 6;  8'h28: return 4;  8'h2C: return 8;
      8'h30: return 5;  8'h34: return 8;  8'h38: return 7;  8'h3C: return 11;
      8'h40, 8'h44: return 2;
      8'h50, 8'h54: return 3;
      8'h60: return 2;  8'h64: return 3;  8'h68: return 1;  8'h6C: return 2;
      8'h70: return 1;  8'h74: return 2;  8'h78: return 1;  8'h7C: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int mCls(input logic [7:0] op);
    if (op == 8'h02) return 2;
    if (op >= 8'h20 && op <= 8'h7F) return 1;
    if (op >= 8'h80 && op <= 8'h9F) return 3;
    if (op >= 8'hA0 && op <= 8'hBF) return 4;
    if (op >= 8'hC0 && op <= 8'hDF) return 5;
    if (op >= 8'hE0 && op <= 8'hE7) return 6;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    idxM = 0; opM = '0; posM = '0; expXs = 0; expRead = 0; expPos = '0; expSize = '0;
    for (int i = 0; i < 8; i++) envM[i] = {8'(224 + i), 24'd0};
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; inValid = 0; inWord = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    modelReset();
  endtask

  task automatic step(input logic v, input logic [31:0] w, input logic rdy, input string tag);
    logic [7:0]   opc;
    logic [255:0] envFlat;
    int           cls;
    logic         fwd, eRdy, eOV, eLast, term, nXs;
    @(negedge clk);
    inValid = v; inWord = w; outReady = rdy;
    #1;
    opc  = (idxM == 0) ? w[31:24] : opM;
    cls  = mCls(opc);
    fwd  = (cls == 1) || (cls == 2) || (cls == 3);
    eRdy = fwd ? rdy : 1'b1;
    eOV  = v && fwd;
    term = ((w & 32'hF000F000) == 32'h50005000);
    if (opc >= 8'h48 && opc <= 8'h4F)      eLast = (idxM >= 3) && term;
    else if (opc >= 8'h58 && opc <= 8'h5F) eLast = (idxM >= 4) && (idxM % 2 == 0) && term;
    else                                   eLast = (idxM == mLen(opc));
    for (int i = 0; i < 8; i++) envFlat[i*32 +: 32] = envM[i];
    chk(tag, "inReady", 256'(inReady), 256'(eRdy));
    chk(tag, "outValid", 256'(outValid), 256'(eOV));
    if (eOV) begin
      chk(tag, "outWord", 256'(outWord), 256'(w));
      chk(tag, "outOpcode", 256'(outOpcode), 256'(opc));
      chk(tag, "outClass", 256'(outClass), 256'(cls));
      chk(tag, "outLast", 256'(outLast), 256'(eLast));
    end
    chk(tag, "envRegs", envRegs, envFlat);
    chk(tag, "xferStart", 256'(xferStart), 256'(expXs));
    if (expXs) begin
      chk(tag, "xferPos", 256'(xferPos), 256'(expPos));
      chk(tag, "xferSize", 256'(xferSize), 256'(expSize));
      chk(tag, "xferRead", 256'(xferRead), 256'(expRead));
    end
    nXs = 0;
    if (v && eRdy) begin
      if (idxM == 0) opM = w[31:24];
      if (cls == 6 && idxM == 0) envM[opc[2:0]] = w;
      if (cls == 4 || cls == 5) begin
        if (idxM == 1) posM = w;
        if (idxM == 2) begin
          nXs = 1; expPos = posM; expSize = w; expRead = (cls == 5);
        end
      end
      idxM = eLast ? 0 : idxM + 1;
    end
    expXs = nXs;
  endtask

  task automatic send(input logic [31:0] w, input string tag);
    step(1'b1, w, 1'b1, tag);
  endtask

  task automatic sendPkt(input logic [7:0] op, input int nParam, input string tag);
    send({op, 24'h00A5C3}, tag);
    for (int k = 1; k <= nParam; k++) send(32'h0100_0100 * k + 32'h11, tag);
  endtask

  initial begin
    modelReset();
    doReset();
    step(1'b0, 32'h0, 1'b1, "R11");

    // fill with a stall on the first parameter
    send(32'h02123456, "R4");
    step(1'b1, 32'h00100020, 1'b0, "R3");
    step(1'b1, 32'h00100020, 1'b0, "R3");
    step(1'b1, 32'h00100020, 1'b1, "R3");
    send(32'h00400040, "R4");

    // no-op opcodes
    send(32'h00000000, "R10");
    send(32'h01ABCDEF, "R10");
    send(32'hE8001234, "R10");
    step(1'b1, 32'hFF123456, 1'b0, "R10");

    // environment writes
    send(32'hE1001234, "R9");
    send(32'hE7FFFFFF, "R9");
    send(32'hE3000ABC, "R9");
    step(1'b0, 32'h0, 1'b1, "R9");

    // fixed-length drawing packets
    sendPkt(8'h20, 3, "R1");
    sendPkt(8'h3C, 11, "R4");
    sendPkt(8'h24, 6, "R4");
    sendPkt(8'h38, 7, "R4");
    sendPkt(8'h40, 2, "R4");
    sendPkt(8'h50, 3, "R4");
    sendPkt(8'h60, 2, "R4");
    sendPkt(8'h6C, 2, "R4");
    sendPkt(8'h7C, 2, "R4");
    sendPkt(8'h68, 1, "R4");

    // monochrome polyline
    send(32'h48FFFFFF, "R5");
    send(32'h50005000, "R5");
    send(32'h5FFF5FFF, "R5");
    send(32'h12345678, "R5");
    send(32'h55555555, "R5");
    send(32'h4A000000, "R5");
    send(32'h00010001, "R5");
    send(32'h00020002, "R5");
    send(32'h50005000, "R5");

    // shaded polyline
    send(32'h58000000, "R6");
    send(32'h00010001, "R6");
    send(32'h00FF00FF, "R6");
    send(32'h50005000, "R6");
    send(32'h00123456, "R6");
    step(1'b1, 32'h5ABC5DEF, 1'b0, "R6");
    send(32'h5ABC5DEF, "R6");
    send(32'h50015002, "R6");

    // copy with stalls
    send(32'h80000000, "R2");
    step(1'b1, 32'h00200010, 1'b0, "R2");
    send(32'h00200010, "R2");
    send(32'h00300040, "R2");
    step(1'b0, 32'h0, 1'b0, "R2");
    send(32'h00080008, "R2");

    // image headers with gaps
    send(32'hA0000000, "R8");
    step(1'b0, 32'h0, 1'b1, "R8");
    send(32'h01230045, "R8");
    step(1'b0, 32'h0, 1'b0, "R8");
    step(1'b0, 32'h0, 1'b1, "R8");
    send(32'h00100020, "R7");
    send(32'hC0000000, "R7");
    send(32'h00AA00BB, "R7");
    send(32'h00020004, "R7");
    send(32'hDF000000, "R7");
    send(32'h00110022, "R7");
    send(32'h00330044, "R7");
    send(32'hBF000000, "R7");
    send(32'h00550066, "R7");
    send(32'h00770088, "R7");
    step(1'b0, 32'h0, 1'b1, "R7");

    // reset in the middle of a packet
    send(32'h3C000000, "R11");
    send(32'h00010001, "R11");
    send(32'hE5000000, "R11");
    doReset();
    step(1'b0, 32'h0, 1'b1, "R11");
    send(32'h02000001, "R11");
    send(32'h00000000, "R11");
    send(32'h00010001, "R11");
    send(32'hE2777777, "R11");
    step(1'b0, 32'h0, 1'b1, "R11");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R3 watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule